// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 14-bit digital-to-analog converter. A host writes to it over an 8-bit or 16-bit data bus using an active-low chip select, an active-low write strobe and two address lines. Inside it keep three registers: an 8-bit low buffer, a 6-bit high buffer, and the 14-bit code register that drives the converter.

A host on a narrow bus writes the low buffer and then the high buffer. It then issues a transfer that moves both buffers into the code register in one step, so the converter never sees a half-written code. A host on a wide bus can instead use the direct mode. In direct mode every register is transparent while the strobes are active, and the bus value is committed when they end.

All strobe, address and data pins are brought into the system clock domain through two-stage synchronizers. A write is active only while both strobes are low. It is committed on the cycle after the synchronized active condition ends, using the address and data seen on the last active cycle.

Top module: `dac_input_register`

## Requirements
- R1: A synchronous active-high reset clears the low buffer, the high buffer and the code register, so `code` reads zero after reset.
- R2: A write is active only while `cs_n` and `wr_n` are both low. Strobes that are low at separate times, never together, change no register.
- R3: With `addr` = 2'b00 (direct mode), `code` follows `bus[13:0]` while the write is active. On release, the bus value is stored in the code register and in both buffers.
- R4: With `addr` = 2'b10 (addr[1]=1, addr[0]=0), the low buffer takes `bus[7:0]`, and `code` does not change.
- R5: With `addr` = 2'b01, the high buffer takes `bus[13:8]`, and `code` does not change.
- R6: With `addr` = 2'b11, the code register takes {high buffer, low buffer}, and the bus is ignored.
- R7: A write is committed when the first of the two strobes rises, whichever strobe that is.
- R8: The committed address and data are the values present on the last synchronized cycle in which both strobes were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Operation select: 00 direct, 10 low buffer, 01 high buffer, 11 transfer |
| bus | input | 14 | Data bus bits 13..0 |
| code | output | 14 | Code driving the converter |

## Verification
When an input changes, it passes through two synchronizer flops, so in direct mode `code` shows the new bus value two clock edges later. A committed write lands on the third edge after the strobe release that ends it. The bench changes inputs on falling edges. It samples transparent output at least three falling edges after a change, and samples committed results four falling edges after the release. No check therefore falls on a cycle where a pipeline register is still moving.

// File: rtl/dac_input_register.sv
module dac_input_register #(
  parameter int DATA_W = 14,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] code
);
  localparam int HIGH_W = DATA_W - LOW_W;
  localparam logic [1:0] OP_DIRECT = 2'b00;
  localparam logic [1:0] OP_HIGH   = 2'b01;
  localparam logic [1:0] OP_LOW    = 2'b10;
  localparam logic [1:0] OP_XFER   = 2'b11;

  logic              cs_s1, cs_s2, wr_s1, wr_s2;
  logic [1:0]        addr_s1, addr_s2, addr_q;
  logic [DATA_W-1:0] bus_s1, bus_s2, bus_q;
  logic              act_q;
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic [DATA_W-1:0] dac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s1 <= 1'b1; cs_s2 <= 1'b1;
      wr_s1 <= 1'b1; wr_s2 <= 1'b1;
      addr_s1 <= '0; addr_s2 <= '0;
      bus_s1 <= '0;  bus_s2 <= '0;
    end else begin
      cs_s1 <= cs_n;   cs_s2 <= cs_s1;
      wr_s1 <= wr_n;   wr_s2 <= wr_s1;
      addr_s1 <= addr; addr_s2 <= addr_s1;
      bus_s1 <= bus;   bus_s2 <= bus_s1;
    end
  end

  wire active  = ~cs_s2 & ~wr_s2;
  wire capture = act_q & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      bus_q  <= '0;
    end else begin
      act_q  <= active;
      addr_q <= addr_s2;
      bus_q  <= bus_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      high_q <= '0;
      dac_q  <= '0;
    end else if (capture) begin
      case (addr_q)
        OP_DIRECT: begin
          low_q  <= bus_q[LOW_W-1:0];
          high_q <= bus_q[DATA_W-1:LOW_W];
          dac_q  <= bus_q;
        end
        OP_LOW:  low_q  <= bus_q[LOW_W-1:0];
        OP_HIGH: high_q <= bus_q[DATA_W-1:LOW_W];
        default: dac_q  <= {high_q, low_q};
      endcase
    end
  end

  wire direct_live = active && (addr_s2 == OP_DIRECT);
  wire direct_cap  = capture && (addr_q == OP_DIRECT);

  assign code = direct_live ? bus_s2 : (direct_cap ? bus_q : dac_q);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (code == '0));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(dac_q) && $stable(low_q) && $stable(high_q)));

  a_r3_direct_commit: assert property (@(posedge clk) disable iff (rst)
    (capture && addr_q == OP_DIRECT) |=> (dac_q == $past(bus_q)));

  a_r4_low_keeps_code: assert property (@(posedge clk) disable iff (rst)
    (capture && addr_q == OP_LOW) |=> ($stable(dac_q) && $stable(high_q)));

  a_r5_high_keeps_code: assert property (@(posedge clk) disable iff (rst)
    (capture && addr_q == OP_HIGH) |=> ($stable(dac_q) && $stable(low_q)));

  a_r6_transfer: assert property (@(posedge clk) disable iff (rst)
    (capture && addr_q == OP_XFER) |=> (dac_q == $past({high_q, low_q})));

  a_r7_one_capture: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);
endmodule

// File: tb/dac_input_register_tb.sv
module dac_input_register_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [13:0] bus = '0;
  logic [13:0] code;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0]  low_m = '0;
  logic [5:0]  high_m = '0;
  logic [13:0] code_m = '0;

  always #4 clk = ~clk;

  dac_input_register u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n),
                            .addr(addr), .bus(bus), .code(code));

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: code=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [13:0] d, input bit cs_first,
                          input int hold, input string req);
    @(negedge clk);
    addr = a; bus = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    if (a == 2'b00 && hold >= 3) check({req, " transparent"}, code, d);
    if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
    @(negedge clk);
    if (cs_first) wr_n = 1'b1; else cs_n = 1'b1;
    bus = ~d;
    case (a)
      2'b00: begin low_m = d[7:0]; high_m = d[13:8]; code_m = d; end
      2'b10: low_m = d[7:0];
      2'b01: high_m = d[13:8];
      default: code_m = {high_m, low_m};
    endcase
    repeat (4) @(negedge clk);
    check(req, code, code_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: code=%h expected=%h", code, code_m);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", code, 14'h0000);
    // R1: transfer right after reset shows zeroed buffers
    do_write(2'b11, 14'h3fff, 1'b0, 4, "R1 R6 buffers zero");

    // R3 R7: direct mode, each release order
    do_write(2'b00, 14'h2a5c, 1'b1, 4, "R3 R7 direct cs-first");
    do_write(2'b00, 14'h15a3, 1'b0, 4, "R3 R7 direct wr-first");

    // R3 R8: bus moves while active, last value is committed
    @(negedge clk);
    addr = 2'b00; bus = 14'h0111; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 follow 1", code, 14'h0111);
    bus = 14'h3222;
    repeat (3) @(negedge clk);
    check("R3 follow 2", code, 14'h3222);
    bus = 14'h0c33;
    repeat (3) @(negedge clk);
    check("R3 follow 3", code, 14'h0c33);
    wr_n = 1'b1;
    @(negedge clk);
    bus = 14'h0000; cs_n = 1'b1;
    low_m = 8'h33; high_m = 6'h0c; code_m = 14'h0c33;
    repeat (4) @(negedge clk);
    check("R8 last active value", code, code_m);

    // R2: strobes low at separate times
    @(negedge clk);
    addr = 2'b00; bus = 14'h1234; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 overlap no write", code, code_m);
    do_write(2'b11, 14'h0000, 1'b1, 3, "R2 buffers untouched");

    // R4 R5 R6: split load then transfer, output changes only on transfer
    for (int i = 0; i < 24; i++) begin
      logic [13:0] d;
      d = 14'((i * 2731 + 977) & 14'h3fff);
      do_write(2'b10, d, i[0], 2 + (i % 3), "R4 low load no output change");
      do_write(2'b01, ~d, ~i[0], 2 + (i % 2), "R5 high load no output change");
      do_write(2'b11, 14'h2aaa ^ d, i[1], 2, "R6 transfer");
      check("R6 combined", code, {~d[13:8], d[7:0]});
    end

    // R3 sweep of direct mode across patterns
    for (int i = 0; i < 16; i++) begin
      do_write(2'b00, 14'(1 << (i % 14)) ^ 14'(i * 37), i[0], 3, "R3 direct sweep");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule